// File: doc/BRIEF.md
# NAND Cached Multi-Page Read Sequencer

This block turns a request for one or more consecutive flash pages into the byte-level command, address and read traffic of a NAND device. A request gives a 24-bit starting row, a 16-bit column and a page count. A mode bit picks the flow. In the cached flow the device loads page k+1 into its array register while page k is read out of the cache register, so the full array read time is spent only once per request. In the plain flow every page is fetched with its own read command, address and confirm.

The sequencer watches the device ready/busy line. It measures the hold, settle and timeout intervals in clock cycles; these are derived from nanosecond parameters and the clock period. Page bytes leave through a one-byte output register with valid/ready flow control, and a device read strobe is issued only when that register can take a byte. A single-cycle done pulse marks the end of a request. A wait that runs past its limit sets an error flag and sends the block back to idle.

Top module: `nand_seqread_ctrl`

## Requirements
- R1: A request with a page count of 1, or with `req_cached` low, uses the plain flow. Each page is fetched as command 0x00, five address bytes, command 0x30, a ready wait that includes tRR, and then one page of read strobes. Commands 0x31 and 0x3F never appear in this flow.
- R2: A cached request with N > 1 pages issues 0x00, the address, 0x30 and a ready wait. It then issues N cache commands, each followed by a ready wait and one page of reads. The first N-1 of these commands are 0x31 and the last is 0x3F.
- R3: The five address bytes go out in this order: col[7:0], col[15:8], row[7:0], row[15:8], row[23:16]. Every 0x30 directly follows an address byte. In the cached flow the address is sent only once.
- R4: In the plain flow, page k of a request is addressed at row+k, and every page after the first uses column 0.
- R5: After a busy-causing command (0x30, 0x31, 0x3F), ready/busy is ignored for a hold interval, and then the block waits for it to read high. A wait that precedes data leaves at least tRR cycles between the rise of ready and the first read strobe. The wait after 0x30 in the cached flow adds no tRR before the next command.
- R6: At most one of the command, address and read strobes is active in any cycle.
- R7: A read strobe is issued only while the output register is empty or being emptied. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R8: Every page delivers exactly PAGE_BYTES bytes, in the order the device returns them. In the cached flow page k holds the data of row+k.
- R9: `done` is high for exactly one cycle, in the cycle after the handshake of the last byte of the last page.
- R10: If a ready wait exceeds its limit, `err` goes high, the block returns to idle and `done` does not pulse. `err` clears when the next request is accepted.
- R11: `req_ready` is high only in idle. A `req_valid` raised while a request is in progress has no effect on the bus traffic.
- R12: A request with a page count of 0 is dropped: no bus strobe and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | High while idle |
| req_row | input | 24 | First page row address |
| req_col | input | 16 | Column address of the first page |
| req_pages | input | PG_W | Number of pages |
| req_cached | input | 1 | Selects the cached flow for multi-page requests |
| bus_cmd_wr | output | 1 | Command byte write strobe |
| bus_addr_wr | output | 1 | Address byte write strobe |
| bus_wdata | output | 8 | Command or address byte |
| bus_rd | output | 1 | Data byte read strobe |
| bus_rdata | input | 8 | Device byte, valid while bus_rd is high |
| bus_rdy | input | 1 | Device ready (1) / busy (0) |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the byte |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Ready-wait timeout flag |

## Verification
A device model drives ready/busy and returns bytes that depend on the row it has loaded and on the byte index. Wrong row sequencing or a lost page therefore shows up as wrong data, not only as wrong command bytes. Cached and plain requests of 1 to 4 pages are compared; this shows whether the 0x31/0x3F chain replaces the per-page re-addressing and whether the row increment carries across an address byte boundary. Each flow is run once with an always-ready consumer and once with a pseudo-random one. This separates the byte-count and back-pressure logic from the command sequencing. Further cases cover a request raised during a busy run, a zero-page request and a ready line that never rises; these exercise the idle gating, the drop path and the timeout abort.

// File: rtl/nand_rd_pkg.sv
`timescale 1ns/1ps
package nand_rd_pkg;

  localparam logic [7:0] OP_READ       = 8'h00;
  localparam logic [7:0] OP_CONFIRM    = 8'h30;
  localparam logic [7:0] OP_CACHE_NEXT = 8'h31;
  localparam logic [7:0] OP_CACHE_LAST = 8'h3F;

  localparam int COL_W    = 16;
  localparam int ROW_W    = 24;
  localparam int ADDR_CYC = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD_RD, S_ADDR, S_CONF, S_WAIT, S_CACHE, S_XFER
  } seq_state_t;

  // Round a duration up to whole clock cycles, never below one cycle.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  // Address byte idx: column low, column high, then row bytes low to high.
  function automatic logic [7:0] addr_byte(input logic [COL_W-1:0] col,
                                           input logic [ROW_W-1:0] row,
                                           input logic [2:0] idx);
    case (idx)
      3'd0:    return col[7:0];
      3'd1:    return col[15:8];
      3'd2:    return row[7:0];
      3'd3:    return row[15:8];
      default: return row[23:16];
    endcase
  endfunction

  function automatic logic [7:0] cache_opcode(input logic last_page);
    return last_page ? OP_CACHE_LAST : OP_CACHE_NEXT;
  endfunction

endpackage

// File: rtl/nand_rb_waiter.sv
`timescale 1ns/1ps
module nand_rb_waiter #(
  parameter int CNT_W    = 16,
  parameter int HOLD_CYC = 20,
  parameter int RR_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             with_rr,
  input  logic [CNT_W-1:0] limit,
  input  logic             rb,
  output logic             ok,
  output logic             timeout,
  output logic             busy
);

  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RR_LAST   = CNT_W'(RR_CYC - 1);

  typedef enum logic [1:0] {W_IDLE, W_HOLD, W_POLL, W_RR} wst_t;

  wst_t             st;
  logic [CNT_W-1:0] phase_cnt;
  logic [CNT_W-1:0] total_cnt;
  logic [CNT_W-1:0] limit_q;
  logic             rr_q;
  logic             rdy_hit_q;
  logic             rb_seen;

  assign busy    = (st != W_IDLE);
  assign rb_seen = (st == W_POLL) && rb;
  assign timeout = busy && (total_cnt == limit_q);
  assign ok      = !timeout &&
                   ((rb_seen && !rr_q) || (st == W_RR && phase_cnt == RR_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      phase_cnt <= '0;
      total_cnt <= '0;
      limit_q   <= '0;
      rr_q      <= 1'b0;
      rdy_hit_q <= 1'b0;
    end else if (start) begin
      st        <= W_HOLD;
      phase_cnt <= '0;
      total_cnt <= '0;
      limit_q   <= limit;
      rr_q      <= with_rr;
      rdy_hit_q <= 1'b0;
    end else if (timeout || ok) begin
      st <= W_IDLE;
    end else begin
      if (busy) total_cnt <= total_cnt + 1'b1;
      case (st)
        W_HOLD: begin
          phase_cnt <= phase_cnt + 1'b1;
          if (phase_cnt == HOLD_LAST) st <= W_POLL;
        end
        W_POLL: if (rb) begin
          st        <= W_RR;
          phase_cnt <= '0;
          rdy_hit_q <= 1'b1;
        end
        W_RR:    phase_cnt <= phase_cnt + 1'b1;
        default: ;
      endcase
    end
  end

  // R5: a wait can only finish once ready has been observed after the hold.
  p_ok_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (rdy_hit_q || rb_seen));

  // R10: an expired wait leaves the waiter idle.
  p_tmo_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !start) |=> !busy);

endmodule

// File: rtl/nand_page_pump.sv
`timescale 1ns/1ps
module nand_page_pump #(
  parameter int PAGE_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       en,
  output logic       bus_rd,
  input  logic [7:0] bus_rdata,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic       page_done
);

  localparam int BC_W = $clog2(PAGE_BYTES + 1);

  logic [BC_W-1:0] remain;
  logic            handshake;

  assign handshake = out_valid && out_ready;
  assign bus_rd    = en && (remain != '0) && (!out_valid || out_ready);
  assign page_done = en && (remain == '0) && handshake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (load) remain <= BC_W'(PAGE_BYTES);
      else if (bus_rd) remain <= remain - 1'b1;
      if (bus_rd) begin
        out_data  <= bus_rdata;
        out_valid <= 1'b1;
      end else if (handshake) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7: a stalled byte stays put.
  p_hold_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: the page ends on a handshake, not on a fresh read.
  p_end_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> !bus_rd);

endmodule

// File: rtl/nand_seqread_ctrl.sv
`timescale 1ns/1ps
module nand_seqread_ctrl
  import nand_rd_pkg::*;
#(
  parameter int CLK_PS     = 5000,
  parameter int T_R_NS     = 20000,
  parameter int T_RCBSY_NS = 5000,
  parameter int T_RR_NS    = 20,
  parameter int T_WB_NS    = 100,
  parameter int TO_MULT    = 4,
  parameter int PAGE_BYTES = 2048,
  parameter int PG_W       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [23:0]     req_row,
  input  logic [15:0]     req_col,
  input  logic [PG_W-1:0] req_pages,
  input  logic            req_cached,
  output logic            bus_cmd_wr,
  output logic            bus_addr_wr,
  output logic [7:0]      bus_wdata,
  output logic            bus_rd,
  input  logic [7:0]      bus_rdata,
  input  logic            bus_rdy,
  output logic            out_valid,
  output logic [7:0]      out_data,
  input  logic            out_ready,
  output logic            done,
  output logic            err
);

  localparam int R_CYC  = ns_to_cycles(T_R_NS, CLK_PS);
  localparam int RC_CYC = ns_to_cycles(T_RCBSY_NS, CLK_PS);
  localparam int RR_CYC = ns_to_cycles(T_RR_NS, CLK_PS);
  localparam int WB_CYC = ns_to_cycles(T_WB_NS, CLK_PS);
  localparam int TO_R   = TO_MULT * R_CYC;
  localparam int TO_RC  = TO_MULT * RC_CYC;
  localparam int TO_MAX = (TO_R > TO_RC) ? TO_R : TO_RC;
  localparam int CNT_W  = $clog2(TO_MAX + WB_CYC + RR_CYC) + 2;

  seq_state_t       st;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [PG_W-1:0]  pages_left;
  logic             cached_q;
  logic             prefetch_q;
  logic [2:0]       addr_idx;
  logic             done_q;
  logic             err_q;

  logic             wait_start, wait_rr, wait_ok, wait_tmo, wait_busy;
  logic [CNT_W-1:0] wait_limit;
  logic             pump_load, pump_en, page_done;
  logic             last_page;

  assign req_ready = (st == S_IDLE);
  assign last_page = (pages_left == PG_W'(1));
  assign done      = done_q;
  assign err       = err_q;

  always_comb begin
    bus_cmd_wr  = 1'b0;
    bus_addr_wr = 1'b0;
    bus_wdata   = 8'h00;
    case (st)
      S_CMD_RD: begin bus_cmd_wr = 1'b1; bus_wdata = OP_READ; end
      S_ADDR:   begin bus_addr_wr = 1'b1; bus_wdata = addr_byte(col_q, row_q, addr_idx); end
      S_CONF:   begin bus_cmd_wr = 1'b1; bus_wdata = OP_CONFIRM; end
      S_CACHE:  begin bus_cmd_wr = 1'b1; bus_wdata = cache_opcode(last_page); end
      default:  ;
    endcase
  end

  assign wait_start = (st == S_CONF) || (st == S_CACHE);
  assign wait_rr    = (st == S_CACHE) || !cached_q;
  assign wait_limit = (st == S_CACHE) ? CNT_W'(TO_RC) : CNT_W'(TO_R);
  assign pump_load  = (st == S_WAIT) && wait_ok && !prefetch_q;
  assign pump_en    = (st == S_XFER);

  nand_rb_waiter #(.CNT_W(CNT_W), .HOLD_CYC(WB_CYC), .RR_CYC(RR_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .start(wait_start), .with_rr(wait_rr),
    .limit(wait_limit), .rb(bus_rdy), .ok(wait_ok), .timeout(wait_tmo),
    .busy(wait_busy)
  );

  nand_page_pump #(.PAGE_BYTES(PAGE_BYTES)) u_pump (
    .clk(clk), .rst_n(rst_n), .load(pump_load), .en(pump_en),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .page_done(page_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      pages_left <= '0;
      cached_q   <= 1'b0;
      prefetch_q <= 1'b0;
      addr_idx   <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && req_pages != '0) begin
          row_q      <= req_row;
          col_q      <= req_col;
          pages_left <= req_pages;
          cached_q   <= req_cached && (req_pages > PG_W'(1));
          err_q      <= 1'b0;
          st         <= S_CMD_RD;
        end
        S_CMD_RD: begin
          addr_idx <= '0;
          st       <= S_ADDR;
        end
        S_ADDR: begin
          addr_idx <= addr_idx + 1'b1;
          if (addr_idx == 3'(ADDR_CYC - 1)) st <= S_CONF;
        end
        S_CONF: begin
          prefetch_q <= cached_q;
          st         <= S_WAIT;
        end
        S_WAIT: begin
          if (wait_tmo) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (wait_ok) begin
            prefetch_q <= 1'b0;
            st         <= prefetch_q ? S_CACHE : S_XFER;
          end
        end
        S_CACHE: st <= S_WAIT;
        S_XFER: if (page_done) begin
          if (last_page) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            pages_left <= pages_left - 1'b1;
            if (cached_q) begin
              st <= S_CACHE;
            end else begin
              row_q <= row_q + 1'b1;
              col_q <= '0;
              st    <= S_CMD_RD;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: confirm always follows an address byte.
  p_conf_after_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_wr && bus_wdata == OP_CONFIRM) |-> $past(bus_addr_wr));

  // R1, R2: cache commands appear only in a multi-page cached run.
  p_cache_cmd_multi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_wr && (bus_wdata == OP_CACHE_NEXT || bus_wdata == OP_CACHE_LAST))
      |-> cached_q);

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_cmd_wr, bus_addr_wr, bus_rd}));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));

  p_err_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (st == S_IDLE && !done));

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !(bus_cmd_wr || bus_addr_wr || bus_rd));

  // R5: data moves only after the wait has finished.
  p_no_wait_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> !wait_busy);

endmodule

// File: tb/tb_nand_seqread_ctrl.sv
`timescale 1ns/1ps
module tb_nand_seqread_ctrl;

  localparam int PAGE = 16;
  localparam int TRR  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_row = '0;
  logic [15:0] req_col = '0;
  logic [7:0]  req_pages = '0;
  logic        req_cached = 1'b0;
  logic        bus_cmd_wr, bus_addr_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_rdy;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic        done, err;

  always #2.5 clk = ~clk;

  nand_seqread_ctrl #(
    .CLK_PS(5000), .T_R_NS(100), .T_RCBSY_NS(50), .T_RR_NS(20),
    .T_WB_NS(10), .TO_MULT(4), .PAGE_BYTES(PAGE), .PG_W(8)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_pages(req_pages),
    .req_cached(req_cached), .bus_cmd_wr(bus_cmd_wr), .bus_addr_wr(bus_addr_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .done(done), .err(err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dev_byte(input logic [23:0] row, input int idx);
    return (row[7:0] * 8'd7) + 8'(idx) ^ row[15:8];
  endfunction

  // ---------------- device model ----------------
  int          busy_cnt = 0;
  bit          stall = 1'b0;
  logic [23:0] addr_row = '0, serve_row = '0, cache_row = '0;
  int          addr_cnt = 0;
  int          rd_idx = 0;

  assign bus_rdy   = (busy_cnt == 0);
  assign bus_rdata = dev_byte(serve_row, rd_idx);

  always @(posedge clk) begin
    if (bus_cmd_wr) begin
      rd_idx <= 0;
      case (bus_wdata)
        8'h00: addr_cnt <= 0;
        8'h30: begin serve_row <= addr_row; cache_row <= addr_row; busy_cnt <= 16; end
        8'h31, 8'h3F: begin serve_row <= cache_row; cache_row <= cache_row + 1; busy_cnt <= 8; end
        default: ;
      endcase
    end else begin
      if (busy_cnt != 0 && !stall) busy_cnt <= busy_cnt - 1;
      if (bus_addr_wr) begin
        addr_cnt <= addr_cnt + 1;
        if (addr_cnt == 2) addr_row[7:0]   <= bus_wdata;
        if (addr_cnt == 3) addr_row[15:8]  <= bus_wdata;
        if (addr_cnt == 4) addr_row[23:16] <= bus_wdata;
      end
      if (bus_rd) rd_idx <= rd_idx + 1;
    end
  end

  // ---------------- consumer ----------------
  bit          rnd_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rnd_ready ? lfsr[0] : 1'b1;
  end

  // ---------------- scoreboard ----------------
  logic [8:0] exp_bus[$];
  logic [7:0] exp_dat[$];
  int         cyc = 0;
  int         rise_cyc = 0;
  int         last_hs_cyc = 0;
  int         done_cnt = 0;
  logic [7:0] last_cmd = 8'hFF;
  bit         rd_pend = 1'b0;
  bit         rb_prev = 1'b1;
  bit         stalled = 1'b0;
  logic [7:0] held = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (bus_rdy && !rb_prev) rise_cyc = cyc;
    rb_prev = bus_rdy;
    chk(int'(bus_cmd_wr) + int'(bus_addr_wr) + int'(bus_rd) <= 1, "R6",
        "strobe count", int'(bus_cmd_wr) + int'(bus_addr_wr) + int'(bus_rd), 1);
    if (bus_cmd_wr || bus_addr_wr) begin
      if (exp_bus.size() == 0) begin
        chk(0, cur_tag, "unexpected bus byte", {bus_addr_wr, bus_wdata}, 0);
      end else begin
        logic [8:0] e;
        e = exp_bus.pop_front();
        chk({bus_addr_wr, bus_wdata} == e, (bus_addr_wr ? "R3" : cur_tag),
            "bus byte", {bus_addr_wr, bus_wdata}, e);
      end
    end
    if (bus_cmd_wr) begin
      if ((bus_wdata == 8'h31 || bus_wdata == 8'h3F) && last_cmd == 8'h30)
        chk(cyc - rise_cyc < TRR, "R5", "extra settle after first load", cyc - rise_cyc, 1);
      if (bus_wdata != 8'h00) rd_pend = 1'b1;
      last_cmd = bus_wdata;
    end
    if (bus_rd) begin
      chk(!(out_valid && !out_ready), "R7", "read while output full", 1, 0);
      if (rd_pend) begin
        chk(cyc - rise_cyc >= TRR, "R5", "ready-to-read gap", cyc - rise_cyc, TRR);
        rd_pend = 1'b0;
      end
    end
    if (stalled) chk(out_valid && out_data == held, "R7", "held byte", out_data, held);
    stalled = out_valid && !out_ready;
    held    = out_data;
    if (out_valid && out_ready) begin
      if (exp_dat.size() == 0) begin
        chk(0, "R8", "unexpected output byte", out_data, 0);
      end else begin
        logic [7:0] d;
        d = exp_dat.pop_front();
        chk(out_data == d, "R8", "output byte", out_data, d);
      end
      last_hs_cyc = cyc;
    end
    if (done) begin
      done_cnt++;
      chk(cyc == last_hs_cyc + 1, "R9", "done timing", cyc, last_hs_cyc + 1);
      chk(exp_dat.size() == 0, "R9", "bytes left at done", exp_dat.size(), 0);
    end
  end

  // ---------------- driver ----------------
  task automatic push_addr(input logic [15:0] col, input logic [23:0] row);
    exp_bus.push_back({1'b1, col[7:0]});
    exp_bus.push_back({1'b1, col[15:8]});
    exp_bus.push_back({1'b1, row[7:0]});
    exp_bus.push_back({1'b1, row[15:8]});
    exp_bus.push_back({1'b1, row[23:16]});
  endtask

  task automatic push_page(input logic [23:0] row);
    for (int i = 0; i < PAGE; i++) exp_dat.push_back(dev_byte(row, i));
  endtask

  task automatic issue(input logic [23:0] row, input logic [15:0] col,
                       input int pages, input bit cached);
    @(posedge clk); #1;
    req_valid = 1'b1; req_row = row; req_col = col;
    req_pages = 8'(pages); req_cached = cached;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int d0;
    d0 = done_cnt;
    for (int i = 0; i < 6000 && done_cnt == d0; i++) @(posedge clk);
    chk(done_cnt == d0 + 1, tag, "done count", done_cnt - d0, 1);
    chk(exp_bus.size() == 0, tag, "bus bytes missing", exp_bus.size(), 0);
    chk(exp_dat.size() == 0, "R8", "data bytes missing", exp_dat.size(), 0);
  endtask

  task automatic run_req(input logic [23:0] row, input logic [15:0] col,
                         input int pages, input bit cached, input string tag);
    cur_tag = tag;
    if (pages != 0) begin
      exp_bus.push_back({1'b0, 8'h00});
      push_addr(col, row);
      exp_bus.push_back({1'b0, 8'h30});
      if (cached && pages > 1) begin
        for (int k = 0; k < pages; k++) begin
          exp_bus.push_back({1'b0, (k == pages - 1) ? 8'h3F : 8'h31});
          push_page(row + 24'(k));
        end
      end else begin
        for (int k = 0; k < pages; k++) begin
          if (k > 0) begin
            exp_bus.push_back({1'b0, 8'h00});
            push_addr(16'h0000, row + 24'(k));
            exp_bus.push_back({1'b0, 8'h30});
          end
          push_page(row + 24'(k));
        end
      end
    end
    issue(row, col, pages, cached);
    if (pages != 0) wait_done(tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- sequence ----------------
  initial begin
    int d0;
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 1'b1, "R11", "reset req_ready", req_ready, 1);
    chk(out_valid == 1'b0, "R7", "reset out_valid", out_valid, 0);
    chk(done == 1'b0, "R9", "reset done", done, 0);
    chk(err == 1'b0, "R10", "reset err", err, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    run_req(24'h000102, 16'h0304, 1, 1'b1, "R1");
    run_req(24'h00A010, 16'h0040, 3, 1'b1, "R2");
    rnd_ready = 1'b1;
    run_req(24'h0A0B0C, 16'h0102, 2, 1'b1, "R2");
    run_req(24'h1234FE, 16'h0800, 3, 1'b0, "R4");
    rnd_ready = 1'b0;
    run_req(24'h7FFFFF, 16'h0010, 4, 1'b1, "R2");

    // R11: a request while busy is ignored
    fork
      run_req(24'h000200, 16'h0000, 2, 1'b1, "R11");
      begin
        repeat (15) @(posedge clk); #1;
        chk(req_ready == 1'b0, "R11", "req_ready while busy", req_ready, 0);
        req_valid = 1'b1; req_row = 24'h555555; req_pages = 8'd3; req_cached = 1'b0;
        repeat (3) @(posedge clk); #1;
        req_valid = 1'b0;
      end
    join
    repeat (40) @(posedge clk);
    chk(exp_bus.size() == 0, "R11", "stray bus bytes", exp_bus.size(), 0);

    // R12: zero page count dropped
    d0 = done_cnt;
    run_req(24'h000300, 16'h0000, 0, 1'b1, "R12");
    repeat (60) @(posedge clk); #1;
    chk(req_ready == 1'b1, "R12", "still idle", req_ready, 1);
    chk(done_cnt == d0, "R12", "no done", done_cnt - d0, 0);
    run_req(24'h000301, 16'h0000, 1, 1'b0, "R12");

    // R10: ready never rises
    cur_tag = "R10";
    stall = 1'b1;
    d0 = done_cnt;
    exp_bus.push_back({1'b0, 8'h00});
    push_addr(16'h0000, 24'h000400);
    exp_bus.push_back({1'b0, 8'h30});
    issue(24'h000400, 16'h0000, 2, 1'b1);
    for (int i = 0; i < 400 && !err; i++) @(posedge clk);
    #1;
    chk(err == 1'b1, "R10", "err after timeout", err, 1);
    chk(req_ready == 1'b1, "R10", "idle after abort", req_ready, 1);
    chk(done_cnt == d0, "R10", "no done on abort", done_cnt - d0, 0);
    chk(exp_bus.size() == 0, "R10", "bus bytes before abort", exp_bus.size(), 0);
    stall = 1'b0;
    repeat (30) @(posedge clk);
    chk(err == 1'b1, "R10", "err holds while idle", err, 1);
    run_req(24'h000410, 16'h0000, 1, 1'b1, "R10");
    chk(err == 1'b0, "R10", "err cleared by new request", err, 0);

    repeat (5) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule